// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each operation request presents the current accumulator byte, one second operand (taken by the surrounding datapath from a register or a memory byte) and a 4-bit operation code. One clock edge later the block returns the 8-bit value to be written back into the accumulator. It also keeps a packed status byte that holds five condition flags: sign, zero, auxiliary (half) carry, even parity and carry.

The carry flag lives inside the block. Add-with-carry and subtract-with-borrow read it as their carry-in, and increment and decrement leave it untouched. A two-state controller tracks whether the output holds a fresh result. `ST_IDLE` means no result is pending. `ST_DONE` means `out_valid` is high for the operation accepted on the previous edge. A request moves the controller from `ST_IDLE` to `ST_DONE` or keeps it in `ST_DONE`. A cycle without a request returns it to `ST_IDLE`. The register file, instruction decode, memory access, decimal adjust and rotates are outside this block.

Top module: `acc_alu`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high and `out_result` holds that operation's result during the following cycle. After an edge with `in_valid` low, `out_valid` is low.
- R2: While reset is asserted, and after it is released, `out_valid` is 0, `out_result` is 0x00 and `out_flags` is 0x02.
- R3: The flag byte is laid out as sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R4: Code 0 (add) returns acc+opnd. Code 1 (add with carry) returns acc+opnd+CY. Both are taken modulo 256, and CY becomes the carry out of bit 7.
- R5: Code 2 (subtract) returns acc−opnd. Code 3 (subtract with borrow) returns acc−opnd−CY. Both are taken modulo 256, and CY is set exactly when opnd plus the borrow-in exceeds acc as unsigned numbers.
- R6: For every code that updates flags (0–6, 8, 9), the sign flag equals result bit 7, the zero flag is set exactly when the result is 0x00, and the parity flag is set exactly when the result has an even number of 1 bits.
- R7: For codes 0–3, 8 and 9, the auxiliary carry is the carry out of bit 3 when the operation is formed as an addition. For add-type codes this is acc + opnd + cin. For subtract-type codes it is acc + ~opnd + (1−borrow-in). Increment is treated as acc+1, and decrement as acc+0xFF.
- R8: Codes 4, 5 and 6 return acc AND, OR and XOR opnd respectively. All three clear CY. AND sets the auxiliary carry, while OR and XOR clear it.
- R9: Code 7 returns the bitwise complement of acc. It ignores opnd and leaves the whole flag byte unchanged.
- R10: Code 8 returns acc+1 and code 9 returns acc−1, both wrapping modulo 256. Both ignore opnd and leave CY unchanged.
- R11: Codes 10–15 return acc unchanged and leave the flag byte unchanged.
- R12: `out_flags` and `out_result` hold their values through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Operation code (see R4–R11) |
| in_acc | input | 8 | Current accumulator value |
| in_opnd | input | 8 | Second operand |
| out_valid | output | 1 | `out_result` holds a new result |
| out_result | output | 8 | Value to write back to the accumulator |
| out_flags | output | 8 | Packed status byte (R3) |

## Verification
The bench targets the wrap points: 0xFF+1 and 0x00−1, both as add/subtract and as increment/decrement. A design that got these wrong would miss the zero flag, set or drop the carry incorrectly, or (for increment and decrement) overwrite the carry it must preserve. It chains add-with-carry and subtract-with-borrow after operations that set and that clear CY. This catches a design that ignores the stored carry or inverts the borrow sense. It probes nibble boundaries such as 0x0F+0x01 and 0x10−0x01 for the auxiliary carry. It checks that complement and the unused codes leave every flag bit alone and that opnd has no effect on them. A random stream with idle gaps exposes results that arrive a cycle late or a `out_valid` that does not drop.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int HALF_W = 4;
    localparam int OP_W   = 4;

    // flag byte bit positions
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_HALF  = 4;
    localparam int FB_PAR   = 2;
    localparam int FB_ONE   = 1;
    localparam int FB_CARRY = 0;

    localparam logic [DATA_W-1:0] FLAGS_RESET = 8'h02;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMA = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } alu_state_e;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W    = 8,
    parameter int HALF = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_cout
);
    localparam int HI_W = W - HALF;

    logic [HALF:0] lo_sum;
    logic [HI_W:0] hi_sum;

    always_comb begin
        lo_sum    = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        hi_sum    = {1'b0, a[W-1:HALF]} + {1'b0, b[W-1:HALF]} + {{HI_W{1'b0}}, lo_sum[HALF]};
        sum       = {hi_sum[HI_W-1:0], lo_sum[HALF-1:0]};
        cout      = hi_sum[HI_W];
        half_cout = lo_sum[HALF];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    input  logic         half_c,
    input  logic         carry,
    output logic [W-1:0] flags
);
    always_comb begin
        flags           = '0;
        flags[FB_SIGN]  = res[W-1];
        flags[FB_ZERO]  = (res == '0);
        flags[FB_HALF]  = half_c;
        flags[FB_PAR]   = ~^res;
        flags[FB_ONE]   = 1'b1;
        flags[FB_CARRY] = carry;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_acc,
    input  logic [DATA_W-1:0] in_opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [DATA_W-1:0] out_flags
);
    alu_state_e        state_q, state_d;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] flags_q;

    logic [DATA_W-1:0] add_b, add_sum, lg_y, res_n, flags_n;
    logic              add_cin, add_cout, add_hc;
    logic              cy_n, ac_n, upd;
    logic_sel_e        lg_sel;
    logic              cy_q;

    assign cy_q = flags_q[FB_CARRY];

    acc_alu_adder #(.W(DATA_W), .HALF(HALF_W)) u_adder (
        .a(in_acc), .b(add_b), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .half_cout(add_hc)
    );

    acc_alu_logic #(.W(DATA_W)) u_logic (
        .a(in_acc), .b(in_opnd), .sel(lg_sel), .y(lg_y)
    );

    acc_alu_status #(.W(DATA_W)) u_status (
        .res(res_n), .half_c(ac_n), .carry(cy_n), .flags(flags_n)
    );

    // operation decode
    always_comb begin
        add_b   = in_opnd;
        add_cin = 1'b0;
        lg_sel  = LG_AND;
        res_n   = in_acc;
        cy_n    = cy_q;
        ac_n    = flags_q[FB_HALF];
        upd     = 1'b0;
        case (in_op)
            OP_ADD: begin
                upd = 1'b1; res_n = add_sum; cy_n = add_cout; ac_n = add_hc;
            end
            OP_ADC: begin
                add_cin = cy_q;
                upd = 1'b1; res_n = add_sum; cy_n = add_cout; ac_n = add_hc;
            end
            OP_SUB: begin
                add_b = ~in_opnd; add_cin = 1'b1;
                upd = 1'b1; res_n = add_sum; cy_n = ~add_cout; ac_n = add_hc;
            end
            OP_SBB: begin
                add_b = ~in_opnd; add_cin = ~cy_q;
                upd = 1'b1; res_n = add_sum; cy_n = ~add_cout; ac_n = add_hc;
            end
            OP_AND: begin
                lg_sel = LG_AND; upd = 1'b1; res_n = lg_y; cy_n = 1'b0; ac_n = 1'b1;
            end
            OP_OR: begin
                lg_sel = LG_OR; upd = 1'b1; res_n = lg_y; cy_n = 1'b0; ac_n = 1'b0;
            end
            OP_XOR: begin
                lg_sel = LG_XOR; upd = 1'b1; res_n = lg_y; cy_n = 1'b0; ac_n = 1'b0;
            end
            OP_CMA: begin
                res_n = ~in_acc;
            end
            OP_INC: begin
                add_b = '0; add_cin = 1'b1;
                upd = 1'b1; res_n = add_sum; ac_n = add_hc;
            end
            OP_DEC: begin
                add_b = '1; add_cin = 1'b0;
                upd = 1'b1; res_n = add_sum; ac_n = add_hc;
            end
            default: begin
                res_n = in_acc;
            end
        endcase
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= FLAGS_RESET;
        end else if (in_valid) begin
            result_q <= res_n;
            if (upd) flags_q <= flags_n;
        end
    end

    assign out_valid  = (state_q == ST_DONE);
    assign out_result = result_q;
    assign out_flags  = flags_q;

    // R1: a request yields a result on the next cycle
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1: no request, no result
    a_r1_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6: sign, zero and parity follow the returned byte
    a_r6_szp_track: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 4'd9 && in_op != 4'd7) |=>
        (out_flags[FB_SIGN] == out_result[DATA_W-1]) &&
        (out_flags[FB_ZERO] == (out_result == '0)) &&
        (out_flags[FB_PAR] == ~^out_result));
    // R8: logical operations clear carry
    a_r8_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd4 && in_op <= 4'd6) |=> !out_flags[FB_CARRY]);
    // R10: increment and decrement keep carry
    a_r10_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd8 || in_op == 4'd9)) |=>
        out_flags[FB_CARRY] == $past(out_flags[FB_CARRY]));
    // R9, R11: complement and unused codes leave flags alone
    a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd7 || in_op >= 4'd10)) |=> $stable(out_flags));
    // R12: nothing moves without a request
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_flags) && $stable(out_result));
    // R3: fixed bits of the status byte
    a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[FB_ONE] && !out_flags[5] && !out_flags[3]);

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_op = '0;
    logic [7:0] in_acc = '0;
    logic [7:0] in_opnd = '0;
    logic       out_valid;
    logic [7:0] out_result;
    logic [7:0] out_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] q_res[$];
    logic [7:0] q_flg[$];
    string      q_tag[$];

    // reference flag state
    logic m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_acc(in_acc), .in_opnd(in_opnd), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pack_flags();
        return {m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
    endfunction

    // driver: computes the expected outcome and pushes it, then drives
    task automatic issue(input int op, input int a, input int b);
        int r;
        int bor;
        bit upd;
        string tag;
        r = a; upd = 1; tag = "R11";
        case (op)
            0, 1: begin
                bor = (op == 1) ? int'(m_cy) : 0;
                r = a + b + bor;
                m_cy = (r > 255);
                m_ac = ((a & 15) + (b & 15) + bor) > 15;
                tag = "R4 R7";
            end
            2, 3: begin
                bor = (op == 3) ? int'(m_cy) : 0;
                r = (a - b - bor) & 255;
                m_cy = (b + bor) > a;
                m_ac = ((a & 15) + ((~b) & 15) + (1 - bor)) > 15;
                tag = "R5 R7";
            end
            4: begin r = a & b; m_cy = 0; m_ac = 1; tag = "R8"; end
            5: begin r = a | b; m_cy = 0; m_ac = 0; tag = "R8"; end
            6: begin r = a ^ b; m_cy = 0; m_ac = 0; tag = "R8"; end
            7: begin r = (~a) & 255; upd = 0; tag = "R9"; end
            8: begin r = (a + 1) & 255; m_ac = (a & 15) == 15; tag = "R10 R7"; end
            9: begin r = (a + 255) & 255; m_ac = (a & 15) != 0; tag = "R10 R7"; end
            default: begin r = a; upd = 0; tag = "R11"; end
        endcase
        r = r & 255;
        if (upd) begin
            m_s = r[7];
            m_z = (r == 0);
            m_p = ~^r[7:0];
        end
        q_res.push_back(r[7:0]);
        q_flg.push_back(pack_flags());
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op[3:0];
        in_acc   = a[7:0];
        in_opnd  = b[7:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_opnd  = 8'hA5;
        end
    endtask

    // monitor: pops and compares when a result appears
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q_res.size() == 0) begin
                    check("R1 unexpected result", {7'd0, out_valid}, 8'd0);
                end else begin
                    string t;
                    t = q_tag.pop_front();
                    check({t, " result"}, out_result, q_res.pop_front());
                    check({t, " R3 R6 flags"}, out_flags, q_flg.pop_front());
                end
            end
        end
    end

    initial begin
        logic [7:0] hold_r, hold_f;
        // R2 reset state
        repeat (3) @(negedge clk);
        check("R2 valid in reset", {7'd0, out_valid}, 8'd0);
        check("R2 flags in reset", out_flags, 8'h02);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 result after reset", out_result, 8'h00);
        check("R2 flags after reset", out_flags, 8'h02);

        // directed corners
        issue(0, 8'hFF, 8'h01);  // wrap, CY, Z, AC
        issue(1, 8'h10, 8'h20);  // uses CY=1
        issue(0, 8'h0F, 8'h01);  // AC only
        issue(1, 8'h01, 8'h01);  // CY=0 in
        issue(2, 8'h00, 8'h01);  // borrow
        issue(3, 8'h05, 8'h02);  // borrow-in 1
        issue(2, 8'h10, 8'h01);  // nibble borrow
        issue(3, 8'h05, 8'h05);  // borrow-in 0, zero
        issue(2, 8'h05, 8'h05);
        issue(3, 8'h00, 8'h00);
        issue(0, 8'h80, 8'h80);  // set CY
        issue(8, 8'hFF, 8'h33);  // INC wrap, keep CY=1
        issue(9, 8'h00, 8'h77);  // DEC wrap
        issue(9, 8'h10, 8'h00);
        issue(8, 8'h7F, 8'h00);
        issue(4, 8'hF0, 8'h3C);
        issue(5, 8'h00, 8'h00);
        issue(6, 8'h5A, 8'h5A);
        issue(0, 8'hC0, 8'hC0);  // CY=1 again
        issue(7, 8'h35, 8'hFF);  // CMA, flags frozen
        issue(12, 8'h9C, 8'h11); // unused code
        issue(15, 8'h00, 8'hFF);
        idle(1);
        @(negedge clk);
        // R1: result stream ended
        check("R1 valid drops", {7'd0, out_valid}, 8'd0);
        hold_r = out_result;
        hold_f = out_flags;
        idle(4);
        check("R12 result held", out_result, hold_r);
        check("R12 flags held", out_flags, hold_f);

        // random stream with gaps
        for (int i = 0; i < 400; i++) begin
            issue(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
        end
        idle(3);
        check("R1 queue drained", 8'(q_res.size()), 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule